// File: doc/BRIEF.md
# Inter-Thread FIFO Cell with Blocking and Non-Blocking Views

This block is one storage cell shared by several hardware threads. It can work as a small first-in first-out queue. Each thread reaches the cell through one access port, and only one access is taken per clock. Every access states four things: whether it reads or writes, which view it uses, its write data, and the index of the thread that issued it. Writes append to the queue. Reads remove the oldest entry and return it. Two tag bits, Empty and Full, follow the fill level of the queue.

The synchronized view makes a thread wait. A read from an empty cell, or a write to a full cell, is not completed. The port reports a stall, and the thread is noted in a parked-thread mask. The next access that does complete sends a one-cycle wake pulse to every parked thread and then clears the mask. The try view never waits. A write to a full cell is dropped, and a read from an empty cell returns zero. A separate configuration input turns queue mode on or off. While queue mode is off, the cell ignores every access.

Top module: `xthread_fifo_cell`

## Requirements
- R1: Data leaves the cell in the order it was written. A completed read returns the oldest stored word on `rsp_rdata`.
- R2: With `req_sync`=1, a read while Empty is set, or a write while Full is set, gives `rsp_stall`=1. The access is not completed: the read data is zero and the queue is unchanged.
- R3: With `req_sync`=0, `rsp_stall` is never raised. A write to a full cell is discarded. A read from an empty cell returns zero and leaves the queue and the tags unchanged.
- R4: While queue mode is off, a read in either view returns zero and a write is ignored. No stall is raised, no wake is raised, and the parked mask is left as it was.
- R5: Any read in queue mode clears Full. Any write in queue mode clears Empty.
- R6: Empty is set when a pop leaves zero entries. Full is set when a push brings the fill count to DEPTH.
- R7: A stalled access sets bit `req_tid` of the parked mask. Later that bit shows up on `wake`.
- R8: An access that completes while the parked mask is nonzero pulses `wake` for one cycle, equal to the mask. The mask is then empty, so later accesses give no further pulse.
- R9: Storage is a ring of DEPTH words. The write slot is the read pointer plus the count, modulo DEPTH. Order holds across pointer wrap-around.
- R10: `rsp_valid`, `rsp_rdata`, `rsp_stall` and `wake` are registered and appear one cycle after the request. After reset: Empty=1, Full=0, the queue is empty, queue mode is off, and nothing is parked.
- R11: A cycle with `cfg_we`=1 loads `cfg_fifo_en` as the queue-mode bit. The new value applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Load the queue-mode bit |
| cfg_fifo_en | input | 1 | New queue-mode value |
| req_valid | input | 1 | An access is presented this cycle |
| req_sync | input | 1 | View select: 1 = synchronized, 0 = try |
| req_write | input | 1 | 1 = write (push), 0 = read (pop) |
| req_wdata | input | DW | Write data |
| req_tid | input | TIDW | Index of the issuing thread |
| rsp_valid | output | 1 | Response for the previous cycle's access |
| rsp_rdata | output | DW | Read data, zero when nothing was popped |
| rsp_stall | output | 1 | The access was parked and not completed |
| wake | output | NTHR | One-cycle wake pulse per thread |
| tag_empty | output | 1 | Empty tag |
| tag_full | output | 1 | Full tag |

## Verification
A fill count that has drifted shows up on the tag outputs within one access. Full or Empty appears at the wrong fill level, or a synchronized access stalls when it should not. A bad read pointer or write slot returns a word in the wrong order on the next pop, and once the ring wraps it returns stale data. A parked mask that is lost, or that is never cleared, shows up on `wake` one cycle after the next completed access: a thread is missing from the pulse, or the pulse appears a second time. The bench compares every response, every wake vector and both tags against a queue model after each access.

// File: rtl/xtf_pkg.sv
package xtf_pkg;
    typedef enum logic {
        VIEW_TRY  = 1'b0,
        VIEW_SYNC = 1'b1
    } view_e;

    typedef enum logic [1:0] {
        ACT_IDLE = 2'd0,
        ACT_PARK = 2'd1,
        ACT_GO   = 2'd2
    } act_e;
endpackage

// File: rtl/xtf_ring.sv
module xtf_ring #(
    parameter int DW    = 64,
    parameter int DEPTH = 4,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = PW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic          pop,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count
);
    typedef struct packed {
        logic [PW-1:0] rd_ptr;
        logic [CW-1:0] count;
    } ring_t;

    ring_t         st_q, st_d;
    logic [DW-1:0] mem_q [DEPTH];
    logic [PW-1:0] slot;

    always_comb begin
        st_d = st_q;
        slot = st_q.rd_ptr + st_q.count[PW-1:0];
        if (push) begin
            st_d.count = st_q.count + CW'(1);
        end
        if (pop) begin
            st_d.rd_ptr = st_q.rd_ptr + PW'(1);
            st_d.count  = st_q.count - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push) mem_q[slot] <= wdata;
    end

    assign head  = mem_q[st_q.rd_ptr];
    assign count = st_q.count;

    p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
        push |-> (st_q.count < CW'(DEPTH)));
    p_no_underflow_r9: assert property (@(posedge clk) disable iff (rst)
        pop |-> (st_q.count != '0));
    p_single_op_r1: assert property (@(posedge clk) disable iff (rst)
        !(push && pop));
    p_count_step_r9: assert property (@(posedge clk) disable iff (rst)
        push |=> (st_q.count == $past(st_q.count) + CW'(1)));
endmodule

// File: rtl/xtf_waitq.sv
module xtf_waitq #(
    parameter int NTHR  = 8,
    localparam int TIDW = (NTHR > 1) ? $clog2(NTHR) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            park,
    input  logic [TIDW-1:0] park_tid,
    input  logic            drain,
    output logic [NTHR-1:0] mask,
    output logic [NTHR-1:0] wake
);
    typedef struct packed {
        logic [NTHR-1:0] mask;
        logic [NTHR-1:0] wake;
    } wq_t;

    wq_t st_q, st_d;

    always_comb begin
        st_d      = st_q;
        st_d.wake = '0;
        if (park) begin
            st_d.mask = st_q.mask | (NTHR'(1) << park_tid);
        end else if (drain) begin
            st_d.wake = st_q.mask;
            st_d.mask = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign mask = st_q.mask;
    assign wake = st_q.wake;

    p_park_sets_bit_r7: assert property (@(posedge clk) disable iff (rst)
        park |=> st_q.mask[$past(park_tid)]);
    p_wake_all_r8: assert property (@(posedge clk) disable iff (rst)
        drain |=> (st_q.wake == $past(st_q.mask)) && (st_q.mask == '0));
    p_park_drain_excl_r8: assert property (@(posedge clk) disable iff (rst)
        !(park && drain));
endmodule

// File: rtl/xthread_fifo_cell.sv
module xthread_fifo_cell
    import xtf_pkg::*;
#(
    parameter int DW    = 64,
    parameter int DEPTH = 4,
    parameter int NTHR  = 8,
    localparam int TIDW = (NTHR > 1) ? $clog2(NTHR) : 1,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_we,
    input  logic            cfg_fifo_en,
    input  logic            req_valid,
    input  logic            req_sync,
    input  logic            req_write,
    input  logic [DW-1:0]   req_wdata,
    input  logic [TIDW-1:0] req_tid,
    output logic            rsp_valid,
    output logic [DW-1:0]   rsp_rdata,
    output logic            rsp_stall,
    output logic [NTHR-1:0] wake,
    output logic            tag_empty,
    output logic            tag_full
);
    typedef struct packed {
        logic          empty;
        logic          full;
        logic          fifo_en;
        logic          rsp_valid;
        logic          rsp_stall;
        logic [DW-1:0] rsp_data;
    } cell_t;

    cell_t           st_q, st_d;
    act_e            act;
    logic            active, blocked, push, pop, drain;
    logic [CW-1:0]   cnt, cnt_after;
    logic [DW-1:0]   head;
    logic [NTHR-1:0] mask;

    always_comb begin
        active  = req_valid && st_q.fifo_en;
        blocked = (view_e'(req_sync) == VIEW_SYNC) &&
                  (req_write ? st_q.full : st_q.empty);
        if (!active)      act = ACT_IDLE;
        else if (blocked) act = ACT_PARK;
        else              act = ACT_GO;

        push      = (act == ACT_GO) && req_write  && (cnt < CW'(DEPTH));
        pop       = (act == ACT_GO) && !req_write && (cnt != '0);
        drain     = (act == ACT_GO) && (mask != '0);
        cnt_after = cnt + CW'(push) - CW'(pop);

        st_d           = st_q;
        st_d.rsp_valid = req_valid;
        st_d.rsp_stall = (act == ACT_PARK);
        st_d.rsp_data  = pop ? head : '0;
        if (cfg_we) st_d.fifo_en = cfg_fifo_en;

        if (active && !req_write) begin
            st_d.full = 1'b0;
            if (act == ACT_GO) st_d.empty = (cnt_after == '0);
        end
        if (active && req_write) begin
            st_d.empty = 1'b0;
            if (act == ACT_GO) st_d.full = (cnt_after == CW'(DEPTH));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q         <= '0;
            st_q.empty   <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    xtf_ring #(.DW(DW), .DEPTH(DEPTH)) u_ring (
        .clk   (clk),
        .rst   (rst),
        .push  (push),
        .pop   (pop),
        .wdata (req_wdata),
        .head  (head),
        .count (cnt)
    );

    xtf_waitq #(.NTHR(NTHR)) u_waitq (
        .clk      (clk),
        .rst      (rst),
        .park     (act == ACT_PARK),
        .park_tid (req_tid),
        .drain    (drain),
        .mask     (mask),
        .wake     (wake)
    );

    assign rsp_valid = st_q.rsp_valid;
    assign rsp_rdata = st_q.rsp_data;
    assign rsp_stall = st_q.rsp_stall;
    assign tag_empty = st_q.empty;
    assign tag_full  = st_q.full;

    p_tags_track_r6: assert property (@(posedge clk) disable iff (rst)
        (st_q.empty == (cnt == '0)) && (st_q.full == (cnt == CW'(DEPTH))));
    p_try_no_stall_r3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_sync) |=> !rsp_stall);
    p_off_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !st_q.fifo_en && !cfg_we) |=>
            (rsp_rdata == '0) && !rsp_stall && (wake == '0));
    p_sync_read_stall_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && st_q.fifo_en && req_sync && !req_write && st_q.empty)
            |=> rsp_stall && $stable(cnt));
    p_rsp_follows_r10: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    p_rsp_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);
endmodule

// File: tb/xthread_fifo_cell_bench.sv
`timescale 1ns/1ps
module xthread_fifo_cell_bench;
    localparam int DW    = 64;
    localparam int DEPTH = 4;
    localparam int NTHR  = 8;
    localparam int TIDW  = 3;

    logic            clk = 1'b0;
    logic            rst;
    logic            cfg_we, cfg_fifo_en;
    logic            req_valid, req_sync, req_write;
    logic [DW-1:0]   req_wdata;
    logic [TIDW-1:0] req_tid;
    logic            rsp_valid, rsp_stall, tag_empty, tag_full;
    logic [DW-1:0]   rsp_rdata;
    logic [NTHR-1:0] wake;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [DW-1:0]   m_q[$];
    bit              m_en   = 0;
    logic [NTHR-1:0] m_mask = '0;

    always #2.5 clk = ~clk;

    xthread_fifo_cell #(.DW(DW), .DEPTH(DEPTH), .NTHR(NTHR)) u_xthread_fifo_cell (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_fifo_en(cfg_fifo_en),
        .req_valid(req_valid), .req_sync(req_sync), .req_write(req_write),
        .req_wdata(req_wdata), .req_tid(req_tid), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .rsp_stall(rsp_stall), .wake(wake),
        .tag_empty(tag_empty), .tag_full(tag_full)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic bit exp_empty();
        return m_q.size() == 0;
    endfunction

    function automatic bit exp_full();
        return m_q.size() == DEPTH;
    endfunction

    task automatic access(input bit sync, input bit wr, input logic [DW-1:0] d,
                          input int tid, input string tag);
        logic [DW-1:0]   e_data  = '0;
        bit              e_stall = 0;
        logic [NTHR-1:0] e_wake  = '0;
        if (m_en) begin
            if (sync && (wr ? exp_full() : exp_empty())) begin
                e_stall = 1;
                m_mask  = m_mask | (NTHR'(1) << tid);
            end else begin
                e_wake = m_mask;
                m_mask = '0;
                if (wr) begin
                    if (m_q.size() < DEPTH) m_q.push_back(d);
                end else if (m_q.size() > 0) begin
                    e_data = m_q.pop_front();
                end
            end
        end
        @(negedge clk);
        req_valid = 1'b1; req_sync = sync; req_write = wr;
        req_wdata = d; req_tid = TIDW'(tid);
        @(negedge clk);
        req_valid = 1'b0;
        chk(rsp_valid == 1'b1, tag, "rsp_valid", DW'(rsp_valid), 1);
        chk(rsp_rdata == e_data, tag, "rdata", rsp_rdata, e_data);
        chk(rsp_stall == e_stall, tag, "stall", DW'(rsp_stall), DW'(e_stall));
        chk(wake == e_wake, tag, "wake", DW'(wake), DW'(e_wake));
        chk(tag_empty == exp_empty(), tag, "empty", DW'(tag_empty), DW'(exp_empty()));
        chk(tag_full == exp_full(), tag, "full", DW'(tag_full), DW'(exp_full()));
    endtask

    task automatic idle_check(input string tag);
        @(negedge clk);
        chk(rsp_valid == 1'b0, tag, "idle rsp_valid", DW'(rsp_valid), 0);
        chk(wake == '0, tag, "idle wake", DW'(wake), 0);
    endtask

    task automatic set_mode(input bit en);
        @(negedge clk);
        cfg_we = 1'b1; cfg_fifo_en = en;
        @(negedge clk);
        cfg_we = 1'b0;
        m_en = en;
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; cfg_we = 1'b0; cfg_fifo_en = 1'b0;
        req_valid = 1'b0; req_sync = 1'b0; req_write = 1'b0;
        req_wdata = '0; req_tid = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(tag_empty == 1'b1, "R10", "reset empty", DW'(tag_empty), 1);
        chk(tag_full == 1'b0, "R10", "reset full", DW'(tag_full), 0);
        chk(rsp_valid == 1'b0, "R10", "reset rsp_valid", DW'(rsp_valid), 0);
        chk(wake == '0, "R10", "reset wake", DW'(wake), 0);

        // R4: queue mode off
        access(0, 1, 64'hAAAA_0000_0000_0001, 1, "R4");
        access(1, 1, 64'hAAAA_0000_0000_0002, 2, "R4");
        access(1, 0, '0, 2, "R4");
        access(0, 0, '0, 3, "R4");

        // R11: enable queue mode
        set_mode(1);
        // R2 / R7: synchronized read on empty parks thread 3
        access(1, 0, '0, 3, "R2");
        access(1, 0, '0, 6, "R7");
        // R8 / R5: a write completes and wakes threads 3 and 6
        access(1, 1, 64'h1111_2222_3333_4444, 0, "R8");
        idle_check("R8");
        access(1, 1, 64'h5555_6666_7777_8888, 1, "R5");
        access(0, 1, 64'h0000_0000_0000_00CC, 1, "R1");
        access(1, 1, 64'hDEAD_BEEF_0000_0001, 2, "R6");
        // R2: synchronized write on full parks thread 5
        access(1, 1, 64'hBAD0_BAD0_BAD0_BAD0, 5, "R2");
        // R3: try write on full is dropped, does not stall, wakes thread 5
        access(0, 1, 64'hBAD1_BAD1_BAD1_BAD1, 4, "R3");
        // R5 / R1: read clears Full, returns oldest
        access(1, 0, '0, 0, "R5");
        access(0, 0, '0, 0, "R1");
        access(1, 0, '0, 0, "R1");
        access(0, 0, '0, 0, "R6");
        // R3: try read on empty returns zero, no stall
        access(0, 0, '0, 7, "R3");
        // R9: wrap the ring several times with three entries resident
        for (int i = 0; i < 3; i++) access(0, 1, DW'(64'h900 + i), 0, "R9");
        for (int i = 0; i < 10; i++) begin
            access(1, 1, DW'(64'hA00 + i), 1, "R9");
            access(1, 0, '0, 1, "R9");
        end
        // R4: mode off again leaves stored data and mask untouched
        access(1, 1, '0, 0, "R4");
        access(1, 1, '0, 2, "R4");
        set_mode(0);
        access(1, 0, '0, 3, "R4");
        access(0, 1, 64'h77, 3, "R4");
        set_mode(1);
        access(0, 0, '0, 3, "R4");

        // R1: random mix
        for (int i = 0; i < 800; i++) begin
            bit s = 1'($urandom % 2);
            bit w = ($urandom % 100) < 52;
            int t = int'($urandom % NTHR);
            logic [DW-1:0] d = {$urandom, $urandom};
            access(s, w, d, t, "R1");
            if ($urandom % 8 == 0) idle_check("R8");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule